// File: doc/BRIEF.md
# Instruction-Boundary Interrupt Arbiter

This block sits beside the execution core. Each time an instruction retires, it decides whether the core must enter an interrupt handler instead of fetching the next instruction, and which vector number to use. The core reports every retirement with a one-cycle strobe and a two-bit class for the retired instruction. With the same strobe it presents the interrupt-enable, trap and overflow flags as they stood when that instruction began. Around the core, a level non-maskable request line and an external request line with its vector (from an interrupt controller) feed the block.

The decision is registered. `take_o` pulses in the cycle after the retirement strobe and carries the chosen vector. `ret_next_o` tells the entry sequence whether the interrupt was caused by the retired instruction itself (high) or by an asynchronous source (low). Instructions that load a stack-related state (enable-interrupts, segment-register moves and pops) form a shadowing class. Nothing is recognised at their boundary, so the following instruction always completes first.

Top module: `irq_boundary_arb`

## Requirements
- R1: While and after reset, with no retirement, `take_o`, `vec_o` and `ret_next_o` are 0 and no non-maskable request is pending.
- R2: `take_o` is high only in the cycle directly after a cycle with `retire_i` high. It is never high otherwise.
- R3: A retirement of class 2 (software interrupt) always produces `take_o` with `vec_o` equal to `sw_vec_i` and `ret_next_o`=1.
- R4: A retirement of class 3 (overflow trap) produces vector 4 with `ret_next_o`=1 when `of_i` is 1. When `of_i` is 0 it produces nothing, unless another source is due.
- R5: A rising edge on `nmi_i` is latched and taken at the next eligible boundary, whatever the value of `if_i`, with vector 2 and `ret_next_o`=0. One edge yields exactly one entry, and a level held high does not retrigger. An edge in the same cycle as the entry that clears the latch stays pending.
- R6: With `if_i`=0, an external request is ignored at the boundary and `take_o` stays low.
- R7: With `if_i`=1, an external request is taken with `vec_o`=`ext_vec_i` and `ret_next_o`=0.
- R8: With `tf_i`=1 at a retirement, a single-step trap on vector 1 with `ret_next_o`=1 follows.
- R9: A retirement of class 1 (shadowing) produces no `take_o`. A latched non-maskable request stays pending and is taken at the next retirement.
- R10: When several sources are due at one boundary, the order is: software/overflow trap, then non-maskable, then external, then single-step. Class 0 is a plain instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | Instruction retired this cycle |
| op_class_i | input | 2 | Retired class: 0 plain, 1 shadowing, 2 software interrupt, 3 overflow trap |
| sw_vec_i | input | VEC_W | Vector operand of a software interrupt |
| if_i | input | 1 | Interrupt-enable flag |
| tf_i | input | 1 | Trap flag at instruction start |
| of_i | input | 1 | Overflow flag |
| nmi_i | input | 1 | Non-maskable request, level |
| ext_req_i | input | 1 | External request from the controller |
| ext_vec_i | input | VEC_W | Vector supplied by the controller |
| take_o | output | 1 | Enter an interrupt (one-cycle pulse) |
| vec_o | output | VEC_W | Vector of the entry |
| ret_next_o | output | 1 | 1: entry caused by the retired instruction itself |

## Verification
Two things can happen in the same cycle: the non-maskable latch is cleared by an entry, and a fresh rising edge on `nmi_i` tries to set it. The bench provokes this with a pulse, a release and then a second rise timed on the retirement that takes the first pulse. It then expects a second vector-2 entry at the next plain boundary. The other collision is a software trap retiring while a non-maskable request, an enabled external request and the trap flag are all present. There the bench expects the software vector first and the non-maskable entry one boundary later, and a random mix compares every boundary against a bench model of the priority order.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
  typedef enum logic [1:0] {
    OPC_PLAIN  = 2'd0,
    OPC_SHADOW = 2'd1,
    OPC_SWINT  = 2'd2,
    OPC_OVTRAP = 2'd3
  } opc_e;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_SW   = 3'd1,
    SRC_OVF  = 3'd2,
    SRC_NMI  = 3'd3,
    SRC_EXT  = 3'd4,
    SRC_STEP = 3'd5
  } src_e;
endpackage

// File: rtl/irqa_nmi_latch.sv
module irqa_nmi_latch (
  input  logic clk,
  input  logic rst,
  input  logic nmi_i,
  input  logic clr_i,
  output logic pend_o
);
  logic nmi_d;
  logic rise;

  assign rise = nmi_i & ~nmi_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_d  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      nmi_d  <= nmi_i;
      // a new edge wins over the clear of the previous one
      pend_o <= rise | (pend_o & ~clr_i);
    end
  end
endmodule

// File: rtl/irqa_prio.sv
module irqa_prio
  import irqa_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int NMI_VEC  = 2,
  parameter int OVF_VEC  = 4,
  parameter int STEP_VEC = 1
) (
  input  logic             retire_i,
  input  opc_e             opc_i,
  input  logic [VEC_W-1:0] sw_vec_i,
  input  logic             if_i,
  input  logic             tf_i,
  input  logic             of_i,
  input  logic             nmi_pend_i,
  input  logic             ext_req_i,
  input  logic [VEC_W-1:0] ext_vec_i,
  output src_e             src_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             ret_next_o
);
  localparam logic [VEC_W-1:0] NMI_V  = VEC_W'(NMI_VEC);
  localparam logic [VEC_W-1:0] OVF_V  = VEC_W'(OVF_VEC);
  localparam logic [VEC_W-1:0] STEP_V = VEC_W'(STEP_VEC);

  always_comb begin
    src_o      = SRC_NONE;
    vec_o      = '0;
    ret_next_o = 1'b0;
    if (retire_i && opc_i != OPC_SHADOW) begin
      if (opc_i == OPC_SWINT) begin
        src_o = SRC_SW;  vec_o = sw_vec_i;  ret_next_o = 1'b1;
      end else if (opc_i == OPC_OVTRAP && of_i) begin
        src_o = SRC_OVF; vec_o = OVF_V;     ret_next_o = 1'b1;
      end else if (nmi_pend_i) begin
        src_o = SRC_NMI; vec_o = NMI_V;
      end else if (ext_req_i && if_i) begin
        src_o = SRC_EXT; vec_o = ext_vec_i;
      end else if (tf_i) begin
        src_o = SRC_STEP; vec_o = STEP_V;   ret_next_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_boundary_arb.sv
module irq_boundary_arb
  import irqa_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int NMI_VEC  = 2,
  parameter int OVF_VEC  = 4,
  parameter int STEP_VEC = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             retire_i,
  input  logic [1:0]       op_class_i,
  input  logic [VEC_W-1:0] sw_vec_i,
  input  logic             if_i,
  input  logic             tf_i,
  input  logic             of_i,
  input  logic             nmi_i,
  input  logic             ext_req_i,
  input  logic [VEC_W-1:0] ext_vec_i,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             ret_next_o
);
  opc_e             opc;
  src_e             src;
  logic [VEC_W-1:0] sel_vec;
  logic             sel_ret;
  logic             nmi_pend;
  logic             nmi_taken;

  assign opc       = opc_e'(op_class_i);
  assign nmi_taken = (src == SRC_NMI);

  irqa_nmi_latch u_nmi (
    .clk    (clk),
    .rst    (rst),
    .nmi_i  (nmi_i),
    .clr_i  (nmi_taken),
    .pend_o (nmi_pend)
  );

  irqa_prio #(
    .VEC_W(VEC_W), .NMI_VEC(NMI_VEC), .OVF_VEC(OVF_VEC), .STEP_VEC(STEP_VEC)
  ) u_prio (
    .retire_i   (retire_i),
    .opc_i      (opc),
    .sw_vec_i   (sw_vec_i),
    .if_i       (if_i),
    .tf_i       (tf_i),
    .of_i       (of_i),
    .nmi_pend_i (nmi_pend),
    .ext_req_i  (ext_req_i),
    .ext_vec_i  (ext_vec_i),
    .src_o      (src),
    .vec_o      (sel_vec),
    .ret_next_o (sel_ret)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o     <= 1'b0;
      vec_o      <= '0;
      ret_next_o <= 1'b0;
    end else begin
      take_o <= (src != SRC_NONE);
      if (src != SRC_NONE) begin
        vec_o      <= sel_vec;
        ret_next_o <= sel_ret;
      end
    end
  end
endmodule

// File: rtl/irqa_chk.sv
module irqa_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             retire_i,
  input logic [1:0]       op_class_i,
  input logic [VEC_W-1:0] sw_vec_i,
  input logic             if_i,
  input logic             tf_i,
  input logic             of_i,
  input logic             ext_req_i,
  input logic             nmi_pend,
  input logic             take_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             ret_next_o
);
  // R2
  take_after_retire_chk: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(retire_i));

  // R3
  swint_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (retire_i && op_class_i == 2'd2) |=>
      (take_o && vec_o == $past(sw_vec_i) && ret_next_o));

  // R9
  shadow_block_chk: assert property (@(posedge clk) disable iff (rst)
    (retire_i && op_class_i == 2'd1) |=> !take_o);

  // R6
  ext_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (retire_i && op_class_i == 2'd0 && !if_i && !tf_i && !nmi_pend) |=> !take_o);

  // R4
  ovf_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (retire_i && op_class_i == 2'd3 && !of_i && !nmi_pend && !(ext_req_i && if_i) && !tf_i)
      |=> !take_o);
endmodule

bind irq_boundary_arb irqa_chk #(.VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .retire_i   (retire_i),
  .op_class_i (op_class_i),
  .sw_vec_i   (sw_vec_i),
  .if_i       (if_i),
  .tf_i       (tf_i),
  .of_i       (of_i),
  .ext_req_i  (ext_req_i),
  .nmi_pend   (nmi_pend),
  .take_o     (take_o),
  .vec_o      (vec_o),
  .ret_next_o (ret_next_o)
);

// File: tb/irq_boundary_arb_tb.sv
`timescale 1ns/1ps
module irq_boundary_arb_tb;
  localparam int VW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          retire_i = 1'b0;
  logic [1:0]    op_class_i = 2'd0;
  logic [VW-1:0] sw_vec_i = '0;
  logic          if_i = 1'b0, tf_i = 1'b0, of_i = 1'b0;
  logic          nmi_i = 1'b0, ext_req_i = 1'b0;
  logic [VW-1:0] ext_vec_i = '0;
  logic          take_o, ret_next_o;
  logic [VW-1:0] vec_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic m_pend = 1'b0;
  logic m_prev = 1'b0;

  always #2.5 clk = ~clk;

  irq_boundary_arb #(.VEC_W(VW)) u_dut (
    .clk(clk), .rst(rst), .retire_i(retire_i), .op_class_i(op_class_i),
    .sw_vec_i(sw_vec_i), .if_i(if_i), .tf_i(tf_i), .of_i(of_i), .nmi_i(nmi_i),
    .ext_req_i(ext_req_i), .ext_vec_i(ext_vec_i),
    .take_o(take_o), .vec_o(vec_o), .ret_next_o(ret_next_o)
  );

  // returns {src[2:0], take, ret_next, vec}; src 0 none,1 sw,2 ovf,3 nmi,4 ext,5 step
  function automatic logic [VW+4:0] expect_of(logic ret, logic [1:0] op, logic [VW-1:0] sv,
      logic f_if, logic f_tf, logic f_of, logic pend, logic ext, logic [VW-1:0] ev);
    if (!ret || op == 2'd1)    return {3'd0, 1'b0, 1'b0, {VW{1'b0}}};
    if (op == 2'd2)            return {3'd1, 1'b1, 1'b1, sv};
    if (op == 2'd3 && f_of)    return {3'd2, 1'b1, 1'b1, VW'(4)};
    if (pend)                  return {3'd3, 1'b1, 1'b0, VW'(2)};
    if (ext && f_if)           return {3'd4, 1'b1, 1'b0, ev};
    if (f_tf)                  return {3'd5, 1'b1, 1'b1, VW'(1)};
    return {3'd0, 1'b0, 1'b0, {VW{1'b0}}};
  endfunction

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // drive at a negedge, let one rising edge pass, check at the next negedge
  task automatic step(string tag, logic ret, logic [1:0] op, logic [VW-1:0] sv,
      logic f_if, logic f_tf, logic f_of, logic nmi, logic ext, logic [VW-1:0] ev);
    logic [VW+4:0] e;
    logic rise;
    retire_i = ret; op_class_i = op; sw_vec_i = sv; if_i = f_if; tf_i = f_tf;
    of_i = f_of; nmi_i = nmi; ext_req_i = ext; ext_vec_i = ev;
    e = expect_of(ret, op, sv, f_if, f_tf, f_of, m_pend, ext, ev);
    rise   = nmi & ~m_prev;
    m_pend = rise | (m_pend & ~(e[VW+4:VW+2] == 3'd3));
    m_prev = nmi;
    @(posedge clk);
    @(negedge clk);
    n_tests++;
    if (take_o !== e[VW+1] ||
        (e[VW+1] && (vec_o !== e[VW-1:0] || ret_next_o !== e[VW]))) begin
      n_fail++;
      $display("FAIL %s src=%0d: take=%0b/%0b vec=%0h/%0h ret_next=%0b/%0b (actual/expected)",
               tag, e[VW+4:VW+2], take_o, e[VW+1], vec_o, e[VW-1:0], ret_next_o, e[VW]);
    end
  endtask

  task automatic idle(string tag, logic nmi);
    step(tag, 1'b0, 2'd0, '0, 1'b0, 1'b0, 1'b0, nmi, 1'b0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_tests++;
    if (take_o !== 1'b0 || vec_o !== '0 || ret_next_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: take=%0b vec=%0h ret_next=%0b expected all 0", take_o, vec_o, ret_next_o);
    end
    rst = 1'b0;
    idle("R1 idle after reset", 1'b0);
    idle("R2 no retire no take", 1'b0);

    step("R3 software int", 1'b1, 2'd2, 8'h21, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    step("R4 overflow trap off", 1'b1, 2'd3, '0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    step("R4 overflow trap on", 1'b1, 2'd3, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, '0);
    step("R6 external masked", 1'b1, 2'd0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h0c);
    step("R7 external taken", 1'b1, 2'd0, '0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h0c);
    step("R8 single step", 1'b1, 2'd0, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);

    // R5: edge with IF clear, level held, taken once
    idle("R5 edge latch", 1'b1);
    step("R5 nmi with IF clear", 1'b1, 2'd0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0);
    step("R5 held level no retrigger", 1'b1, 2'd0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0);
    // R5: new edge in the cycle the latch is cleared
    idle("R5 release", 1'b0);
    idle("R5 first edge", 1'b1);
    idle("R5 drop", 1'b0);
    step("R5 take while new edge", 1'b1, 2'd0, '0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, '0);
    step("R5 second entry", 1'b1, 2'd0, '0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, '0);
    idle("R5 release", 1'b0);

    // R9: shadow blocks nmi, ext and step; nmi taken after the following instruction
    idle("R9 edge", 1'b1);
    step("R9 shadow boundary", 1'b1, 2'd1, '0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h40);
    step("R9 after shadow", 1'b1, 2'd0, '0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, '0);
    idle("R9 release", 1'b0);

    // R10: everything due at once
    idle("R10 edge", 1'b1);
    step("R10 software first", 1'b1, 2'd2, 8'h80, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h33);
    step("R10 nmi next", 1'b1, 2'd0, '0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h33);
    step("R10 external before step", 1'b1, 2'd0, '0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h33);
    step("R10 overflow before nmi", 1'b1, 2'd3, '0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, '0);
    step("R10 nmi after overflow", 1'b1, 2'd0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0);

    for (int i = 0; i < 400; i++) begin
      logic nmi_n;
      nmi_n = (($urandom % 6) == 0) ? ~m_prev : m_prev;
      step("random", (($urandom % 4) != 0), 2'($urandom % 4), VW'($urandom),
           1'($urandom), (($urandom % 4) == 0), 1'($urandom), nmi_n,
           1'($urandom), VW'($urandom));
    end
    report();
  end
endmodule